// File: doc/BRIEF.md
# Multi-Channel Delay, Frequency-Shift and Scale Emulator

The block takes a single stream of complex baseband samples and builds up to eight altered replicas of it, which it adds into one output stream. Each replica, or channel, has its own enable, sample delay, oscillator increment and gain. A channel stores the samples it accepts in a circular memory and reads back the sample accepted a chosen number of samples earlier. It rotates that sample by a complex oscillator whose phase steps by the channel's increment, scales the result by an unsigned fraction, and passes it to a common adder. The adder rounds and saturates the total back to the input width. A typical use is to emulate several point reflectors, each with its own range, radial speed and strength, from a radar's own transmitted waveform.

A timestamp enters with each sample and leaves with the matching output, so a downstream scheduler can time the emitted stream against the received one. The register inputs are plain ports. All four registers of a channel are taken in the same cycle as the sample they apply to, and they travel down the pipeline with it.

Top module: `dly_dop_mix`

## Requirements
- R1: Up to 8 channels (parameter `NCH`) work on the same input sample, and the output is the sum of their scaled contributions, rounded and saturated once after the sum.
- R2: A channel whose enable bit is 0 for a sample contributes zero for that sample, writes nothing to its memory and does not advance its phase.
- R3: For the n-th sample accepted by an enabled channel with delay D, the channel uses the (n-D)-th accepted sample. D = 0 uses the current sample. A channel that has accepted fewer than D samples since reset uses zero.
- R4: A delay value above 255 (2^`DLY_AW` - 1) acts as 255.
- R5: A channel's phase is 0 after reset and steps by the channel's 32-bit increment, modulo 2^32, after each accepted sample. The top two phase bits select the quadrant: 0 gives (cos, sin) = (32767, 0), 2^30 gives (0, 32767), 2^31 gives (-32767, 0) and 3*2^30 gives (0, -32767). With delayed sample (xi, xq), mi = floor((xi*cos - xq*sin + 2^14) / 2^15) and mq = floor((xi*sin + xq*cos + 2^14) / 2^15).
- R6: Gain is an unsigned 16-bit fraction g. The contribution is (mi*g, mq*g), and each output component is floor((sum + 2^15) / 2^16).
- R7: An output component beyond the signed 16-bit range is clamped to 32767 or -32768.
- R8: A cycle with the input valid low writes no memory, advances no phase, and its output slot has valid low and both data components 0.
- R9: The output valid, data and timestamp for an input cycle appear exactly 5 clock edges after the edge that samples that input.
- R10: While reset is low, and right after it, the output valid is 0 and both data components and the timestamp are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase component, signed |
| in_q | input | 16 | Input quadrature component, signed |
| in_ts | input | 64 | Timestamp of the input sample |
| ch_en | input | NCH | Per-channel enable, bit k for channel k |
| ch_dly | input | NCH*16 | Per-channel delay in samples, channel k at bits [16k+15:16k] |
| ch_inc | input | NCH*32 | Per-channel phase increment, channel k at bits [32k+31:32k] |
| ch_gain | input | NCH*16 | Per-channel unsigned Q0.16 gain, channel k at bits [16k+15:16k] |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Output in-phase component, signed |
| out_q | output | 16 | Output quadrature component, signed |
| out_ts | output | 64 | Timestamp paired with the output sample |

## Verification
Every result falls due at one point: the data, valid and timestamp for an input are due five clock edges after the edge that takes the input, whether that input was valid or idle. The bench drives on the falling edge and files each expected result in a slot five falling edges ahead. It compares the ports against that slot at the falling edge, half a period after the fifth rising edge, so an output that is early or late by one cycle is compared against another sample's values. Delay and phase depend on how many samples each channel has accepted, not on cycles, so the reference model counts accepted samples per channel, and idle cycles and disabled channels add nothing to those counts.

// File: rtl/dly_dop_pkg.sv
package dly_dop_pkg;

   // register stages inside one channel: read/lookup, rotate, scale
   localparam int CH_LAT  = 3;
   // register stages in the combiner: add, round/saturate
   localparam int SUM_LAT = 2;
   // total input-to-output latency in clock edges
   localparam int LAT     = CH_LAT + SUM_LAT;

   // oscillator quadrant taken from the two top phase bits
   typedef enum logic [1:0] {
      QUAD_0 = 2'd0,
      QUAD_1 = 2'd1,
      QUAD_2 = 2'd2,
      QUAD_3 = 2'd3
   } quad_e;

endpackage

// File: rtl/ddm_delay_line.sv
module ddm_delay_line #(
   parameter int DW    = 16,
   parameter int AW    = 8,
   parameter int DLY_W = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [DLY_W-1:0]     dly,
   input  logic signed [DW-1:0] wi,
   input  logic signed [DW-1:0] wq,
   output logic signed [DW-1:0] ri,
   output logic signed [DW-1:0] rq
);

   localparam int            DEPTH = 1 << AW;
   localparam logic [AW-1:0] DMAX  = AW'(DEPTH - 1);

   logic [2*DW-1:0] mem [DEPTH];
   logic [AW-1:0]   wp;
   logic [AW-1:0]   fill;
   logic [AW-1:0]   d_eff;
   logic [AW-1:0]   ra;

   // delays beyond the memory reach act as the deepest tap
   always_comb begin
      if (dly > DLY_W'(DEPTH - 1)) begin
         d_eff = DMAX;
      end else begin
         d_eff = dly[AW-1:0];
      end
      ra = wp - d_eff;
   end

   always_ff @(posedge clk) begin
      if (we) begin
         mem[wp] <= {wi, wq};
      end
   end

   // fill counts accepted samples, saturating at the deepest tap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         fill <= '0;
      end else if (we) begin
         wp <= wp + AW'(1);
         if (fill != DMAX) begin
            fill <= fill + AW'(1);
         end
      end
   end

   always_comb begin
      if (d_eff == '0) begin
         ri = wi;
         rq = wq;
      end else if (fill >= d_eff) begin
         {ri, rq} = mem[ra];
      end else begin
         ri = '0;
         rq = '0;
      end
   end

endmodule

// File: rtl/ddm_nco.sv
module ddm_nco
   import dly_dop_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int LUT_AW = 8,
   parameter int DW     = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic [ACC_W-1:0]     inc,
   output logic signed [DW-1:0] cos_o,
   output logic signed [DW-1:0] sin_o
);

   localparam int              QN   = 1 << LUT_AW;
   localparam logic [LUT_AW:0] QNV  = (LUT_AW+1)'(QN);
   localparam real             AMP  = real'((1 << (DW-1)) - 1);
   localparam real             HPI  = 1.5707963267948966;

   logic signed [DW-1:0] qtab [QN+1];
   logic [ACC_W-1:0]     ph;
   quad_e                q_s;
   quad_e                q_c;
   logic [LUT_AW-1:0]    idx;

   // quarter-wave table with both end points, built at elaboration
   for (genvar k = 0; k <= QN; k++) begin : g_tab
      localparam real ANG = HPI * real'(k) / real'(QN);
      localparam int  VAL = int'($floor(AMP * $sin(ANG) + 0.5));
      assign qtab[k] = DW'(VAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (adv) begin
         ph <= ph + inc;
      end
   end

   function automatic logic signed [DW-1:0] fold(input quad_e q, input logic [LUT_AW-1:0] ix);
      logic [LUT_AW:0] dir;
      logic [LUT_AW:0] mir;
      dir = {1'b0, ix};
      mir = QNV - dir;
      case (q)
         QUAD_0:  fold =  qtab[dir];
         QUAD_1:  fold =  qtab[mir];
         QUAD_2:  fold = -qtab[dir];
         default: fold = -qtab[mir];
      endcase
   endfunction

   always_comb begin
      q_s   = quad_e'(ph[ACC_W-1 -: 2]);
      q_c   = quad_e'(ph[ACC_W-1 -: 2] + 2'd1);
      idx   = ph[ACC_W-3 -: LUT_AW];
      sin_o = fold(q_s, idx);
      cos_o = fold(q_c, idx);
   end

endmodule

// File: rtl/ddm_channel.sv
module ddm_channel #(
   parameter int DW     = 16,
   parameter int DLY_AW = 8,
   parameter int DLY_W  = 16,
   parameter int ACC_W  = 32,
   parameter int LUT_AW = 8,
   parameter int GW     = 16,
   localparam int MW    = DW + 1,
   localparam int PW    = MW + GW + 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   input  logic                 en,
   input  logic [DLY_W-1:0]     dly,
   input  logic [ACC_W-1:0]     inc,
   input  logic [GW-1:0]        gain,
   output logic signed [PW-1:0] p_i,
   output logic signed [PW-1:0] p_q
);

   localparam int                   XW  = 2*DW + 1;
   localparam logic signed [XW-1:0] RND = XW'(1) <<< (DW-2);

   logic                 accept;
   logic signed [DW-1:0] rd_i, rd_q;
   logic signed [DW-1:0] nco_c, nco_s;

   // stage 1: delayed sample, oscillator value, gain
   logic signed [DW-1:0] x1_i, x1_q, c1, s1;
   logic [GW-1:0]        g1;
   // stage 2: rotated sample
   logic signed [MW-1:0] m2_i, m2_q;
   logic [GW-1:0]        g2;

   logic signed [2*DW-1:0] pa, pb, pc, pd;
   logic signed [XW-1:0]   r_i, r_q;

   assign accept = in_valid & en;

   ddm_delay_line #(
      .DW    (DW),
      .AW    (DLY_AW),
      .DLY_W (DLY_W)
   ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (accept),
      .dly   (dly),
      .wi    (in_i),
      .wq    (in_q),
      .ri    (rd_i),
      .rq    (rd_q)
   );

   ddm_nco #(
      .ACC_W  (ACC_W),
      .LUT_AW (LUT_AW),
      .DW     (DW)
   ) u_nco (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (accept),
      .inc   (inc),
      .cos_o (nco_c),
      .sin_o (nco_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1_i <= '0;
         x1_q <= '0;
         c1   <= '0;
         s1   <= '0;
         g1   <= '0;
      end else begin
         x1_i <= accept ? rd_i : '0;
         x1_q <= accept ? rd_q : '0;
         c1   <= nco_c;
         s1   <= nco_s;
         g1   <= gain;
      end
   end

   // complex rotation with round-half-up back to one guard bit
   always_comb begin
      pa  = (2*DW)'(x1_i) * (2*DW)'(c1);
      pb  = (2*DW)'(x1_q) * (2*DW)'(s1);
      pc  = (2*DW)'(x1_i) * (2*DW)'(s1);
      pd  = (2*DW)'(x1_q) * (2*DW)'(c1);
      r_i = XW'(pa) - XW'(pb) + RND;
      r_q = XW'(pc) + XW'(pd) + RND;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m2_i <= '0;
         m2_q <= '0;
         g2   <= '0;
      end else begin
         m2_i <= MW'(r_i >>> (DW-1));
         m2_q <= MW'(r_q >>> (DW-1));
         g2   <= g1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_i <= '0;
         p_q <= '0;
      end else begin
         p_i <= PW'(m2_i) * PW'($signed({1'b0, g2}));
         p_q <= PW'(m2_q) * PW'($signed({1'b0, g2}));
      end
   end

endmodule

// File: rtl/ddm_sum_sat.sv
module ddm_sum_sat #(
   parameter int NCH = 8,
   parameter int PW  = 34,
   parameter int GW  = 16,
   parameter int DW  = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH*PW-1:0]    pi_flat,
   input  logic [NCH*PW-1:0]    pq_flat,
   output logic signed [DW-1:0] sum_i,
   output logic signed [DW-1:0] sum_q
);

   localparam int                   SW   = PW + $clog2(NCH) + 1;
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (GW-1);
   localparam logic signed [SW-1:0] HI   = SW'((1 <<< (DW-1)) - 1);
   localparam logic signed [SW-1:0] LO   = -HI - SW'(1);

   logic signed [SW-1:0] tot_i_n, tot_q_n;
   logic signed [SW-1:0] tot_i, tot_q;

   always_comb begin
      tot_i_n = '0;
      tot_q_n = '0;
      for (int k = 0; k < NCH; k++) begin
         tot_i_n = tot_i_n + SW'($signed(pi_flat[k*PW +: PW]));
         tot_q_n = tot_q_n + SW'($signed(pq_flat[k*PW +: PW]));
      end
   end

   function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] v);
      logic signed [SW-1:0] r;
      r = (v + HALF) >>> GW;
      if (r > HI) begin
         rnd_sat = DW'(HI);
      end else if (r < LO) begin
         rnd_sat = DW'(LO);
      end else begin
         rnd_sat = DW'(r);
      end
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_i <= '0;
         tot_q <= '0;
         sum_i <= '0;
         sum_q <= '0;
      end else begin
         tot_i <= tot_i_n;
         tot_q <= tot_q_n;
         sum_i <= rnd_sat(tot_i);
         sum_q <= rnd_sat(tot_q);
      end
   end

endmodule

// File: rtl/dly_dop_mix.sv
module dly_dop_mix
   import dly_dop_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int DW     = 16,
   parameter int DLY_W  = 16,
   parameter int DLY_AW = 8,
   parameter int ACC_W  = 32,
   parameter int LUT_AW = 8,
   parameter int GW     = 16,
   parameter int TS_W   = 64
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   input  logic [TS_W-1:0]      in_ts,
   input  logic [NCH-1:0]       ch_en,
   input  logic [NCH*DLY_W-1:0] ch_dly,
   input  logic [NCH*ACC_W-1:0] ch_inc,
   input  logic [NCH*GW-1:0]    ch_gain,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_i,
   output logic signed [DW-1:0] out_q,
   output logic [TS_W-1:0]      out_ts
);

   localparam int PW = DW + 1 + GW + 1;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("NCH must lie in 1..8");
   end
   if (DLY_W < DLY_AW) begin : g_bad_dly
      $error("DLY_W must cover DLY_AW");
   end
   if (ACC_W < LUT_AW + 2) begin : g_bad_acc
      $error("ACC_W must exceed LUT_AW by at least two quadrant bits");
   end
   if (LAT < 2) begin : g_bad_lat
      $error("pipeline latency below two stages");
   end

   logic [NCH*PW-1:0] pi_flat, pq_flat;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [PW-1:0] p_i, p_q;

      ddm_channel #(
         .DW     (DW),
         .DLY_AW (DLY_AW),
         .DLY_W  (DLY_W),
         .ACC_W  (ACC_W),
         .LUT_AW (LUT_AW),
         .GW     (GW)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .in_i     (in_i),
         .in_q     (in_q),
         .en       (ch_en[c]),
         .dly      (ch_dly[c*DLY_W +: DLY_W]),
         .inc      (ch_inc[c*ACC_W +: ACC_W]),
         .gain     (ch_gain[c*GW +: GW]),
         .p_i      (p_i),
         .p_q      (p_q)
      );

      assign pi_flat[c*PW +: PW] = p_i;
      assign pq_flat[c*PW +: PW] = p_q;
   end

   ddm_sum_sat #(
      .NCH (NCH),
      .PW  (PW),
      .GW  (GW),
      .DW  (DW)
   ) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .pi_flat (pi_flat),
      .pq_flat (pq_flat),
      .sum_i   (out_i),
      .sum_q   (out_q)
   );

   // sideband valid and timestamp, matched to the data latency
   logic [LAT-1:0]  v_pipe;
   logic [TS_W-1:0] ts_pipe [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pipe <= '0;
      end else begin
         v_pipe <= {v_pipe[LAT-2:0], in_valid};
      end
   end

   for (genvar s = 0; s < LAT; s++) begin : g_ts
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ts_pipe[s] <= '0;
         end else if (s == 0) begin
            ts_pipe[s] <= in_ts;
         end else begin
            ts_pipe[s] <= ts_pipe[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign out_valid = v_pipe[LAT-1];
   assign out_ts    = ts_pipe[LAT-1];

endmodule

// File: rtl/dly_dop_mix_chk.sv
module dly_dop_mix_chk #(
   parameter int NCH  = 8,
   parameter int DW   = 16,
   parameter int TS_W = 64
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [TS_W-1:0]      in_ts,
   input logic [NCH-1:0]       ch_en,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_i,
   input logic signed [DW-1:0] out_q,
   input logic [TS_W-1:0]      out_ts
);

   // edges seen since reset release, saturating
   logic [2:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
      end else if (since != 3'd7) begin
         since <= since + 3'd1;
      end
   end

   // R9: timestamp leaves five edges after it enters
   a_r9_ts_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd5) |-> (out_ts == $past(in_ts, 5)));

   // R9: valid leaves five edges after it enters
   a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

   // R8: an idle slot carries zero data
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_i == '0 && out_q == '0));

   // R2: a sample taken with every channel off yields zero
   a_r2_all_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((since >= 3'd5) && $past(ch_en == '0, 5) && $past(in_valid, 5))
      |-> (out_i == '0 && out_q == '0));

   // R10: nothing valid in the first edges after reset
   a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (since < 3'd5) |-> !out_valid);

endmodule

bind dly_dop_mix dly_dop_mix_chk #(
   .NCH  (NCH),
   .DW   (DW),
   .TS_W (TS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ts     (in_ts),
   .ch_en     (ch_en),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q),
   .out_ts    (out_ts)
);

// File: tb/tb_dly_dop_mix.sv
`timescale 1ns/1ps
module tb_dly_dop_mix;

   localparam int NCH  = 8;
   localparam int MAXD = 255;
   localparam int HMAX = 300;
   localparam int LATE = 5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic signed [15:0]  in_i = '0;
   logic signed [15:0]  in_q = '0;
   logic [63:0]         in_ts = '0;
   logic [NCH-1:0]      ch_en;
   logic [NCH*16-1:0]   ch_dly;
   logic [NCH*32-1:0]   ch_inc;
   logic [NCH*16-1:0]   ch_gain;
   logic                out_valid;
   logic signed [15:0]  out_i, out_q;
   logic [63:0]         out_ts;

   logic        cfg_en  [NCH];
   logic [15:0] cfg_d   [NCH];
   logic [31:0] cfg_inc [NCH];
   logic [15:0] cfg_g   [NCH];

   always #10 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NCH; k++) begin
         ch_en[k]            = cfg_en[k];
         ch_dly[k*16 +: 16]  = cfg_d[k];
         ch_inc[k*32 +: 32]  = cfg_inc[k];
         ch_gain[k*16 +: 16] = cfg_g[k];
      end
   end

   dly_dop_mix dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .in_ts     (in_ts),
      .ch_en     (ch_en),
      .ch_dly    (ch_dly),
      .ch_inc    (ch_inc),
      .ch_gain   (ch_gain),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q),
      .out_ts    (out_ts)
   );

   // stimulus table: {in_i, in_q, channel-0 gain}
   localparam logic [47:0] VEC [10] = '{
      48'h03E8_0000_FFFF,
      48'hFC18_07D0_8000,
      48'h7FFF_8000_FFFF,
      48'h8000_7FFF_0001,
      48'h0001_FFFF_4000,
      48'h1234_EDCC_C000,
      48'h0000_0000_FFFF,
      48'h4000_C000_0000,
      48'h7FFF_7FFF_2000,
      48'h8000_8000_FFFF
   };

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   bit done  = 0;
   logic [63:0] ts_ctr = 64'h1000;

   // reference model state
   longint      hist_i [NCH][HMAX];
   longint      hist_q [NCH][HMAX];
   int          cnt    [NCH];
   logic [31:0] ph     [NCH];

   // expected results, indexed by falling-edge count
   bit          slot_set [8];
   logic        slot_v   [8];
   longint      slot_i   [8];
   longint      slot_q   [8];
   logic [63:0] slot_ts  [8];
   string       slot_tag [8];

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic v, input logic signed [15:0] xi, input logic signed [15:0] xq,
                        output longint oi, output longint oq);
      longint ai, aq;
      ai = 0;
      aq = 0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (v && cfg_en[ch]) begin
            int d;
            longint si, sq, c, s, mi, mq;
            d = (int'(cfg_d[ch]) > MAXD) ? MAXD : int'(cfg_d[ch]);
            hist_i[ch][cnt[ch]] = xi;
            hist_q[ch][cnt[ch]] = xq;
            si = 0;
            sq = 0;
            if (cnt[ch] >= d) begin
               si = hist_i[ch][cnt[ch]-d];
               sq = hist_q[ch][cnt[ch]-d];
            end
            cnt[ch]++;
            case (ph[ch][31:30])
               2'd0:    begin c = 32767;  s = 0;      end
               2'd1:    begin c = 0;      s = 32767;  end
               2'd2:    begin c = -32767; s = 0;      end
               default: begin c = 0;      s = -32767; end
            endcase
            ph[ch] = ph[ch] + cfg_inc[ch];
            mi = (si*c - sq*s + 16384) >>> 15;
            mq = (si*s + sq*c + 16384) >>> 15;
            ai += mi * longint'(cfg_g[ch]);
            aq += mq * longint'(cfg_g[ch]);
         end
      end
      ai = (ai + 32768) >>> 16;
      aq = (aq + 32768) >>> 16;
      oi = (ai > 32767) ? 32767 : ((ai < -32768) ? -32768 : ai);
      oq = (aq > 32767) ? 32767 : ((aq < -32768) ? -32768 : aq);
   endtask

   task automatic step(input logic v, input logic signed [15:0] xi, input logic signed [15:0] xq,
                       input string tag, input int g0 = -1);
      int k;
      longint ei, eq;
      @(negedge clk);
      k = cyc % 8;
      if (slot_set[k]) begin
         chk(slot_tag[k], "out_valid", longint'(out_valid), longint'(slot_v[k]));
         chk(slot_tag[k], "out_i", longint'(out_i), slot_i[k]);
         chk(slot_tag[k], "out_q", longint'(out_q), slot_q[k]);
         chk("R9", "out_ts", longint'(out_ts), longint'(slot_ts[k]));
         slot_set[k] = 0;
      end
      if (g0 >= 0) cfg_g[0] = 16'(g0);
      in_valid = v;
      in_i     = xi;
      in_q     = xq;
      in_ts    = ts_ctr;
      model(v, xi, xq, ei, eq);
      k = (cyc + LATE) % 8;
      slot_set[k] = 1;
      slot_v[k]   = v;
      slot_i[k]   = v ? ei : 0;
      slot_q[k]   = v ? eq : 0;
      slot_ts[k]  = ts_ctr;
      slot_tag[k] = v ? tag : "R8";
      ts_ctr = ts_ctr + 64'd7;
      cyc++;
   endtask

   task automatic flush;
      for (int k = 0; k < LATE + 1; k++) step(1'b0, 16'sd0, 16'sd0, "R8");
   endtask

   task automatic do_reset;
      in_valid = 1'b0;
      in_ts    = '0;
      rst_n    = 1'b0;
      for (int k = 0; k < NCH; k++) begin
         cfg_en[k]  = 1'b0;
         cfg_d[k]   = '0;
         cfg_inc[k] = '0;
         cfg_g[k]   = '0;
         cnt[k]     = 0;
         ph[k]      = '0;
      end
      for (int k = 0; k < 8; k++) slot_set[k] = 0;
      repeat (2) @(negedge clk);
      chk("R10", "out_valid in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      chk("R10", "out_valid", longint'(out_valid), 0);
      chk("R10", "out_i", longint'(out_i), 0);
      chk("R10", "out_q", longint'(out_q), 0);
      chk("R10", "out_ts", longint'(out_ts), 0);
      cyc = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // reset state, R10
      do_reset();

      // R6, R1: single channel, table of samples and gains
      do_reset();
      cfg_en[0] = 1'b1;
      for (int k = 0; k < 10; k++) begin
         step(1'b1, VEC[k][47:32], VEC[k][31:16], "R6", int'(VEC[k][15:0]));
      end
      flush();

      // R7: all channels at full gain drive the sum past both limits
      do_reset();
      for (int k = 0; k < NCH; k++) begin
         cfg_en[k] = 1'b1;
         cfg_g[k]  = 16'hFFFF;
      end
      for (int k = 0; k < 3; k++) step(1'b1, 16'sh7FFF, -16'sh8000, "R7");
      for (int k = 0; k < 3; k++) step(1'b1, -16'sh8000, 16'sh7FFF, "R7");
      step(1'b1, 16'sd1000, -16'sd1000, "R1");
      flush();

      // R2: a disabled channel with gain set contributes nothing
      do_reset();
      cfg_en[0] = 1'b1; cfg_g[0] = 16'h8000;
      cfg_en[1] = 1'b0; cfg_g[1] = 16'hFFFF; cfg_inc[1] = 32'h4000_0000;
      cfg_en[2] = 1'b1; cfg_g[2] = 16'h4000; cfg_d[2] = 16'd1;
      for (int k = 0; k < 6; k++) step(1'b1, 16'(3000 + 500*k), 16'(-2000 + 300*k), "R2");
      flush();

      // R3, R1: delayed and direct channels summed
      do_reset();
      cfg_en[0] = 1'b1; cfg_g[0] = 16'hFFFF; cfg_d[0] = 16'd3;
      cfg_en[1] = 1'b1; cfg_g[1] = 16'h4000; cfg_d[1] = 16'd0;
      for (int k = 0; k < 10; k++) step(1'b1, 16'(100*(k+1)), 16'(-50*(k+1)), "R3");
      flush();

      // R5: quarter, half and three-quarter turn per sample
      do_reset();
      cfg_en[0] = 1'b1; cfg_g[0] = 16'hFFFF; cfg_inc[0] = 32'h4000_0000;
      cfg_en[1] = 1'b1; cfg_g[1] = 16'h8000; cfg_inc[1] = 32'h8000_0000;
      cfg_en[2] = 1'b1; cfg_g[2] = 16'h2000; cfg_inc[2] = 32'hC000_0000;
      for (int k = 0; k < 9; k++) step(1'b1, 16'sd1000, 16'sd500, "R5");
      flush();

      // R8: idle cycles hold both the delay history and the phase
      do_reset();
      cfg_en[0] = 1'b1; cfg_g[0] = 16'hFFFF; cfg_d[0] = 16'd2; cfg_inc[0] = 32'h4000_0000;
      step(1'b1, 16'sd1200, 16'sd0,   "R8");
      step(1'b0, 16'sd9999, 16'sd999, "R8");
      step(1'b1, 16'sd2400, 16'sd100, "R8");
      step(1'b1, 16'sd3600, 16'sd200, "R8");
      step(1'b0, 16'sd7777, 16'sd777, "R8");
      step(1'b0, 16'sd5555, 16'sd555, "R8");
      step(1'b1, 16'sd4800, 16'sd300, "R8");
      step(1'b1, 16'sd6000, 16'sd400, "R8");
      step(1'b1, 16'sd7200, 16'sd500, "R8");
      flush();

      // R4: out-of-range delay acts as the deepest tap
      do_reset();
      cfg_en[0] = 1'b1; cfg_g[0] = 16'hFFFF; cfg_d[0] = 16'd1000;
      for (int k = 0; k < 262; k++) step(1'b1, 16'(k+1), 16'(-k), "R4");
      flush();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule